// File: doc/BRIEF.md
# Clock Alarm Event Capture Register

This block sits beside a telecom clock synchronizer and watches four status levels: primary reference lost, secondary reference lost, PLL in holdover and PLL unlocked. Each level passes through a synchronizer. Its live value can be read in a status byte. Every rising and every falling transition of each level is latched into its own bit of an event byte. Reading that byte returns the collected bits and clears them.

While any event bit is pending, the block holds a level interrupt high. A host reaches the block through a small byte-wide bus over a window of eight register offsets. The status byte also carries a nibble of writable output-enable bits, which drive the block's enable outputs. An identification register reports the configured interrupt number.

Top module: `clkmon_alarm_capture`

## Requirements
- R1: After reset, `irq_o` is 0, `out_en_o` is 4'h0, `bus_rdata_o` is 8'h00 and no event bit is set.
- R2: A read at offset 2 returns the status byte. Bit 7 is primary loss, bit 6 is secondary loss, bit 5 is holdover and bit 4 is unlock. Each of these follows its input after a two-flop synchronizer. Bits 3:0 return the current `out_en_o`.
- R3: Event byte layout (offset 6): a rising edge of primary loss sets bit 0 and a falling edge sets bit 1. Secondary loss uses bits 2 and 3, holdover uses bits 4 and 5, and unlock uses bits 6 and 7. An event bit is set three clock edges after the input changes.
- R4: A read at offset 6 returns the accumulated event bits and clears all of them.
- R5: If an edge is captured on the same clock edge as an event-byte read, the read returns the old value and the new bit stays set for the next read.
- R6: `irq_o` is high exactly while at least one event bit is pending. It stays high until a read clears every pending bit.
- R7: A write at offset 2 loads `bus_wdata_i[3:0]` into `out_en_o` and ignores bits 7:4. Writes to any other offset have no effect, including offset 6, which does not clear events.
- R8: A read at offset 7 returns {4'h0, IRQ_NUM}. The value 4'hF means the clock hardware is absent.
- R9: Levels already present at reset release cause no event. No event is taken until the synchronizer pipeline has been refilled.
- R10: Read data appears on `bus_rdata_o` one cycle after the read strobe and holds until the next read. Offsets 0, 1, 3, 4 and 5 read as 8'h00.
- R11: Events accumulate. Several edges before one read, including a rise and a fall of the same input, all show in that read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| pri_lost_i | input | 1 | Primary reference lost, asynchronous level |
| sec_lost_i | input | 1 | Secondary reference lost, asynchronous level |
| holdover_i | input | 1 | PLL holdover, asynchronous level |
| unlock_i | input | 1 | PLL unlocked, asynchronous level |
| bus_addr_i | input | 3 | Register offset |
| bus_rd_i | input | 1 | Read strobe, one cycle per access |
| bus_wr_i | input | 1 | Write strobe, one cycle per access |
| bus_wdata_i | input | 8 | Write data |
| bus_rdata_o | output | 8 | Registered read data |
| out_en_o | output | 4 | Output-enable bits from the status byte |
| irq_o | output | 1 | Level interrupt, event pending |

## Verification
A lost or stuck edge-detector history bit shows up as a missing or spurious event-byte bit. It becomes visible on the first read after the input toggles, which is four cycles after the change. A clear that drops a coincident edge appears only in the read after a read/edge collision, so that collision is forced on the exact capture edge. A wrong interrupt state is visible on `irq_o` in the cycle after an event is set or cleared. A stale output-enable nibble appears both on `out_en_o` and in the low nibble of the next status read.

// File: rtl/clkmon_pkg.sv
package clkmon_pkg;
  localparam int unsigned N_SRC   = 4;
  localparam int unsigned N_EVT   = 2 * N_SRC;
  localparam int unsigned ADDR_W  = 3;
  localparam int unsigned DATA_W  = 8;
  localparam int unsigned EN_W    = DATA_W - N_SRC;

  // source index: 0 primary loss, 1 secondary loss, 2 holdover, 3 unlock
  localparam int unsigned SRC_PRI  = 0;
  localparam int unsigned SRC_SEC  = 1;
  localparam int unsigned SRC_HOLD = 2;
  localparam int unsigned SRC_UNLK = 3;

  localparam logic [ADDR_W-1:0] OFF_STATUS = 3'd2;
  localparam logic [ADDR_W-1:0] OFF_EVENT  = 3'd6;
  localparam logic [ADDR_W-1:0] OFF_ID     = 3'd7;
endpackage

// File: rtl/clkmon_sync.sv
module clkmon_sync #(
  parameter int unsigned WIDTH  = 4,
  parameter int unsigned STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] async_i,
  output logic [WIDTH-1:0] sync_o
);
  logic [WIDTH-1:0] stage_q [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    if (s == 0) begin : g_first
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) stage_q[s] <= '0;
        else         stage_q[s] <= async_i;
      end
    end else begin : g_next
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) stage_q[s] <= '0;
        else         stage_q[s] <= stage_q[s-1];
      end
    end
  end

  assign sync_o = stage_q[STAGES-1];
endmodule

// File: rtl/clkmon_edge_capture.sv
module clkmon_edge_capture #(
  parameter int unsigned N_SRC  = 4,
  parameter int unsigned STAGES = 2,
  localparam int unsigned N_EVT = 2 * N_SRC,
  localparam int unsigned PRIME = STAGES + 1,
  localparam int unsigned CNT_W = $clog2(PRIME + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [N_SRC-1:0] lvl_i,
  input  logic             clr_i,
  output logic [N_EVT-1:0] evt_o
);
  logic [N_SRC-1:0] prev_q;
  logic [CNT_W-1:0] prime_q;
  logic             armed;
  logic [N_EVT-1:0] hit;
  logic [N_EVT-1:0] evt_q;

  // hold off capture until the synchronizer and history hold real levels
  assign armed = (prime_q == CNT_W'(PRIME));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     prime_q <= '0;
    else if (!armed) prime_q <= prime_q + 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) prev_q <= '0;
    else         prev_q <= lvl_i;
  end

  for (genvar i = 0; i < N_SRC; i++) begin : g_edge
    assign hit[2*i]   = armed &  lvl_i[i] & ~prev_q[i];
    assign hit[2*i+1] = armed & ~lvl_i[i] &  prev_q[i];
  end

  // clear applies to the old bits only; a coincident edge survives
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) evt_q <= '0;
    else         evt_q <= (clr_i ? '0 : evt_q) | hit;
  end

  assign evt_o = evt_q;
endmodule

// File: rtl/clkmon_regs.sv
module clkmon_regs
  import clkmon_pkg::*;
#(
  parameter logic [3:0] IRQ_NUM = 4'h5
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              rd_i,
  input  logic              wr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic [N_SRC-1:0]  status_i,
  input  logic [N_EVT-1:0]  evt_i,
  output logic              evt_clr_o,
  output logic [EN_W-1:0]   en_o,
  output logic [DATA_W-1:0] rdata_o
);
  logic [EN_W-1:0]   en_q;
  logic [DATA_W-1:0] rdata_q;
  logic [DATA_W-1:0] rd_mux;
  logic              unused_wdata;

  assign unused_wdata = ^wdata_i[DATA_W-1:EN_W];
  assign evt_clr_o    = rd_i && (addr_i == OFF_EVENT);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                              en_q <= '0;
    else if (wr_i && (addr_i == OFF_STATUS))  en_q <= wdata_i[EN_W-1:0];
  end

  always_comb begin
    rd_mux = '0;
    unique case (addr_i)
      OFF_STATUS: rd_mux = {status_i, en_q};
      OFF_EVENT:  rd_mux = evt_i;
      OFF_ID:     rd_mux = {4'h0, IRQ_NUM};
      default:    rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   rdata_q <= '0;
    else if (rd_i) rdata_q <= rd_mux;
  end

  assign en_o    = en_q;
  assign rdata_o = rdata_q;
endmodule

// File: rtl/clkmon_alarm_capture.sv
module clkmon_alarm_capture
  import clkmon_pkg::*;
#(
  parameter logic [3:0]  IRQ_NUM     = 4'h5,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              pri_lost_i,
  input  logic              sec_lost_i,
  input  logic              holdover_i,
  input  logic              unlock_i,
  input  logic [ADDR_W-1:0] bus_addr_i,
  input  logic              bus_rd_i,
  input  logic              bus_wr_i,
  input  logic [DATA_W-1:0] bus_wdata_i,
  output logic [DATA_W-1:0] bus_rdata_o,
  output logic [EN_W-1:0]   out_en_o,
  output logic              irq_o
);
  logic [N_SRC-1:0] raw_lvl;
  logic [N_SRC-1:0] sync_lvl;
  logic [N_SRC-1:0] status_nib;
  logic [N_EVT-1:0] evt;
  logic             evt_clr;

  assign raw_lvl[SRC_PRI]  = pri_lost_i;
  assign raw_lvl[SRC_SEC]  = sec_lost_i;
  assign raw_lvl[SRC_HOLD] = holdover_i;
  assign raw_lvl[SRC_UNLK] = unlock_i;

  clkmon_sync #(.WIDTH(N_SRC), .STAGES(SYNC_STAGES)) i_sync (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .async_i (raw_lvl),
    .sync_o  (sync_lvl)
  );

  clkmon_edge_capture #(.N_SRC(N_SRC), .STAGES(SYNC_STAGES)) i_capture (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .lvl_i  (sync_lvl),
    .clr_i  (evt_clr),
    .evt_o  (evt)
  );

  // status high nibble is source-reversed: primary loss in the top bit
  for (genvar i = 0; i < N_SRC; i++) begin : g_status
    assign status_nib[N_SRC-1-i] = sync_lvl[i];
  end

  clkmon_regs #(.IRQ_NUM(IRQ_NUM)) i_regs (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .addr_i    (bus_addr_i),
    .rd_i      (bus_rd_i),
    .wr_i      (bus_wr_i),
    .wdata_i   (bus_wdata_i),
    .status_i  (status_nib),
    .evt_i     (evt),
    .evt_clr_o (evt_clr),
    .en_o      (out_en_o),
    .rdata_o   (bus_rdata_o)
  );

  assign irq_o = |evt;
endmodule

// File: rtl/clkmon_alarm_capture_chk.sv
module clkmon_alarm_capture_chk #(
  parameter logic [3:0] IRQ_NUM = 4'h5
) (
  input logic       clk_i,
  input logic       rst_ni,
  input logic [2:0] bus_addr_i,
  input logic       bus_rd_i,
  input logic       bus_wr_i,
  input logic [7:0] bus_rdata_o,
  input logic [3:0] out_en_o,
  input logic       irq_o
);
  logic [2:0] cyc_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)               cyc_q <= '0;
    else if (cyc_q != 3'd7)    cyc_q <= cyc_q + 1'b1;
  end

  p_no_early_irq_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cyc_q <= 3'd3) |-> !irq_o);

  p_irq_hold_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq_o && !(bus_rd_i && bus_addr_i == 3'd6)) |=> irq_o);

  p_read_pending_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bus_rd_i && bus_addr_i == 3'd6 && irq_o) |=> (bus_rdata_o != 8'h00));

  p_id_value_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bus_rd_i && bus_addr_i == 3'd7) |=> (bus_rdata_o == {4'h0, IRQ_NUM}));

  p_en_stable_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(bus_wr_i && bus_addr_i == 3'd2) |=> $stable(out_en_o));

  p_status_low_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bus_rd_i && !bus_wr_i && bus_addr_i == 3'd2) |=> (bus_rdata_o[3:0] == out_en_o));

  p_zero_offsets_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bus_rd_i && bus_addr_i != 3'd2 && bus_addr_i != 3'd6 && bus_addr_i != 3'd7)
    |=> (bus_rdata_o == 8'h00));

  p_rdata_hold_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !bus_rd_i |=> $stable(bus_rdata_o));
endmodule

bind clkmon_alarm_capture clkmon_alarm_capture_chk #(.IRQ_NUM(IRQ_NUM)) i_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .bus_addr_i  (bus_addr_i),
  .bus_rd_i    (bus_rd_i),
  .bus_wr_i    (bus_wr_i),
  .bus_rdata_o (bus_rdata_o),
  .out_en_o    (out_en_o),
  .irq_o       (irq_o)
);

// File: tb/test_clkmon_alarm_capture.sv
`timescale 1ns/1ps
module test_clkmon_alarm_capture;
  localparam logic [3:0] IRQ_NUM = 4'h5;

  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       pri_lost_i = 1'b0, sec_lost_i = 1'b0, holdover_i = 1'b1, unlock_i = 1'b0;
  logic [2:0] bus_addr_i = '0;
  logic       bus_rd_i = 1'b0, bus_wr_i = 1'b0;
  logic [7:0] bus_wdata_i = '0;
  logic [7:0] bus_rdata_o;
  logic [3:0] out_en_o;
  logic       irq_o;

  int n_chk = 0;
  int n_err = 0;

  typedef struct {
    logic [7:0] exp;
    string      tag;
  } sb_item_t;
  sb_item_t sb_q[$];

  always #2 clk_i = ~clk_i;

  clkmon_alarm_capture #(.IRQ_NUM(IRQ_NUM)) i_clkmon_alarm_capture (
    .clk_i, .rst_ni, .pri_lost_i, .sec_lost_i, .holdover_i, .unlock_i,
    .bus_addr_i, .bus_rd_i, .bus_wr_i, .bus_wdata_i, .bus_rdata_o, .out_en_o, .irq_o
  );

  task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual 0x%02h expected 0x%02h", tag, act, exp);
    end
  endtask

  // all tasks start and end on a falling edge
  task automatic rd(input logic [2:0] a, input logic [7:0] exp, input string tag);
    bus_addr_i = a;
    bus_rd_i   = 1'b1;
    sb_q.push_back('{exp: exp, tag: tag});
    @(negedge clk_i);
    bus_rd_i   = 1'b0;
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    bus_addr_i  = a;
    bus_wdata_i = d;
    bus_wr_i    = 1'b1;
    @(negedge clk_i);
    bus_wr_i    = 1'b0;
  endtask

  task automatic settle();
    repeat (4) @(negedge clk_i);
  endtask

  // monitor: compare each read result one cycle after its strobe
  initial begin
    forever begin
      @(posedge clk_i);
      if (bus_rd_i) begin
        @(negedge clk_i);
        if (sb_q.size() == 0) begin
          n_chk++; n_err++;
          $display("FAIL scoreboard: unexpected read result 0x%02h expected none", bus_rdata_o);
        end else begin
          sb_item_t it;
          it = sb_q.pop_front();
          check(it.tag, bus_rdata_o, it.exp);
        end
      end
    end
  end

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  endtask

  initial begin
    #(200000 * 4);
    n_chk++; n_err++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk_i);
    check("R1 irq at reset", {7'h0, irq_o}, 8'h00);
    check("R1 out_en at reset", {4'h0, out_en_o}, 8'h00);
    check("R1 rdata at reset", bus_rdata_o, 8'h00);
    rst_ni = 1'b1;
    repeat (6) @(negedge clk_i);

    // R9: holdover was high through reset, must not appear as an event
    check("R9 irq after reset", {7'h0, irq_o}, 8'h00);
    rd(3'd6, 8'h00, "R9 no event from reset level");
    rd(3'd2, 8'h20, "R2 status holdover bit 5");
    rd(3'd7, {4'h0, IRQ_NUM}, "R8 id register");
    for (int a = 0; a < 6; a++)
      if (a != 2) rd(3'(a), 8'h00, "R10 unused offset reads zero");

    // R3 single rising edge
    pri_lost_i = 1'b1;
    settle();
    check("R6 irq high on pending", {7'h0, irq_o}, 8'h01);
    rd(3'd2, 8'hA0, "R2 status primary+holdover");
    rd(3'd6, 8'h01, "R3 primary rise bit 0");
    check("R6 irq low after clear", {7'h0, irq_o}, 8'h00);
    rd(3'd6, 8'h00, "R4 event cleared by read");

    // falls of primary and holdover
    pri_lost_i = 1'b0; holdover_i = 1'b0;
    settle();
    rd(3'd6, 8'h22, "R3 primary fall bit1 holdover fall bit5");

    sec_lost_i = 1'b1; unlock_i = 1'b1;
    settle();
    rd(3'd2, 8'h50, "R2 status secondary+unlock");
    rd(3'd6, 8'h44, "R3 secondary rise bit2 unlock rise bit6");
    sec_lost_i = 1'b0; unlock_i = 1'b0;
    settle();
    rd(3'd6, 8'h88, "R3 secondary fall bit3 unlock fall bit7");

    // R11 rise then fall before one read
    holdover_i = 1'b1;
    settle();
    holdover_i = 1'b0;
    settle();
    check("R6 irq stays high with two pending", {7'h0, irq_o}, 8'h01);
    rd(3'd6, 8'h30, "R11 holdover rise and fall accumulate");

    // R7 enable writes
    wr(3'd2, 8'hFA);
    check("R7 out_en takes low nibble", {4'h0, out_en_o}, 8'h0A);
    rd(3'd2, 8'h0A, "R7 status low nibble only");
    wr(3'd0, 8'hFF);
    wr(3'd3, 8'h05);
    check("R7 other offsets ignored", {4'h0, out_en_o}, 8'h0A);
    pri_lost_i = 1'b1;
    settle();
    wr(3'd6, 8'h00);
    check("R7 write to event offset keeps irq", {7'h0, irq_o}, 8'h01);
    rd(3'd6, 8'h01, "R7 write to event offset does not clear");

    // R5 edge captured on the same edge as the read
    pri_lost_i = 1'b0;
    @(negedge clk_i);
    @(negedge clk_i);
    rd(3'd6, 8'h00, "R5 coincident read returns old value");
    check("R5 new event keeps irq", {7'h0, irq_o}, 8'h01);
    rd(3'd6, 8'h02, "R5 coincident edge kept for next read");
    check("R6 irq low after final clear", {7'h0, irq_o}, 8'h00);

    repeat (3) @(negedge clk_i);
    if (sb_q.size() != 0) begin
      n_chk++; n_err++;
      $display("FAIL scoreboard: actual %0d pending expected 0", sb_q.size());
    end
    finish_run();
  end
endmodule